// File: doc/BRIEF.md
# MIPS Subset Instruction Decoder

This block is the combinational decode and control stage for a 32-bit MIPS subset core. It takes one instruction word and produces, in the same cycle, the controls the execute and write-back stages need. These are the ALU function, the source of the shift amount, how the 16-bit immediate is widened, whether ALU operand B comes from the register file or the immediate, the destination register index, and the register write enable. Each word is also classed as a jump, a branch, a load or a store.

Register arithmetic, immediate arithmetic, both forms of shift, and load-upper-immediate are decoded completely and write a result. Control transfers and memory accesses are recognised and flagged so that later stages can be added. For now they carry a write enable of zero, so they cannot change any register. An all-zero word decodes as a shift into register 0, which writes nothing and so acts as a no-op.

The primary opcode is bits 31..26. Opcode 0 selects a group decoded by the function field in bits 5..0. Opcode 1 selects a group decoded by bits 20..16.

Top module: `mips_subset_decoder`

## Requirements
- R1: With opcode 0, the function codes 0x21, 0x23, 0x24, 0x25, 0x26, 0x27, 0x2A and 0x2B give ALU select 0 (add), 1 (sub), 2 (and), 3 (or), 4 (xor), 5 (nor), 6 (set-less-signed) and 7 (set-less-unsigned). Each gives operand-B select 0 (register), destination bits 15..11, and write enable 1 when that index is nonzero.
- R2: The opcodes 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E and 0x0F give ALU select 0, 6, 7, 2, 3, 4 and 11 (pass B). Each gives operand-B select 1 (immediate), destination bits 20..16, and write enable 1 when that index is nonzero.
- R3: Extension mode is 1 (zero-extend) for opcodes 0x0C, 0x0D and 0x0E. It is 2 (place in upper half) for 0x0F. It is 0 (sign-extend) for 0x09, 0x0A, 0x0B and for every other word.
- R4: With opcode 0, the function codes 0x00, 0x02 and 0x03 give ALU select 8, 9 and 10 (shift left, shift right logical, shift right arithmetic) with shift-source 0 (bits 10..6). The codes 0x04, 0x06 and 0x07 give the same three selects with shift-source 1 (low bits of the rs register). All other words give shift-source 0.
- R5: Write enable is 0 whenever the destination index is 0. An all-zero word gives write enable 0, no class flag, ALU select 8 and destination 0.
- R6: Opcodes 0x02 and 0x03, and function codes 0x08 and 0x09 under opcode 0, raise the jump flag. They give write enable 0, destination 0, and ALU select, shift source, extension and operand-B select all 0.
- R7: Opcodes 0x04 to 0x07, and opcode 1 with bits 20..16 equal to 0 or 1, raise the branch flag. The other outputs are the same as in R6.
- R8: Opcodes 0x20, 0x23 and 0x24 raise the load flag, and 0x28 and 0x2B raise the store flag. Each gives write enable 0, destination 0, ALU select 0, sign extension, and operand-B select 1.
- R9: At most one of the four class flags is high at a time, and no ALU-class instruction raises any of them.
- R10: Any other encoding drives every output to 0. Examples are opcode 1 with other values in bits 20..16, unused function codes, and unused opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| alu_op_o | output | 4 | ALU function select |
| shift_src_o | output | 1 | 0: shift amount from bits 10..6, 1: from rs |
| ext_mode_o | output | 2 | 0 sign, 1 zero, 2 upper-half |
| opb_sel_o | output | 1 | 0: register operand B, 1: immediate |
| dest_idx_o | output | 5 | Destination register index |
| reg_we_o | output | 1 | Register write enable |
| is_jump_o | output | 1 | Jump class |
| is_branch_o | output | 1 | Branch class |
| is_load_o | output | 1 | Load class |
| is_store_o | output | 1 | Store class |

## Verification
The bench targets several corner cases, and each one catches a different decoder error.

- Writes to register 0 from both the register form and the immediate form: a missing zero guard would show a write enable with destination 0.
- Link-style jumps that name register 31 in their rd or implied target: a decoder that let them write would change architectural state.
- The opcode-1 group, where a wrong bits 20..16 compare would flag a branch for an illegal word or miss a real one.
- The pairs that differ in one bit: constant and variable shifts, signed and unsigned compare, zero- and sign-extended immediates. A swapped case entry changes exactly one output field for these words.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int ALU_W   = 4;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_XOR = 4'd4, ALU_NOR = 4'd5, ALU_SLT = 4'd6, ALU_SLTU = 4'd7,
    ALU_SLL = 4'd8, ALU_SRL = 4'd9, ALU_SRA = 4'd10, ALU_PASSB = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {EXT_SIGN = 2'd0, EXT_ZERO = 2'd1, EXT_UPPER = 2'd2} ext_mode_e;
  typedef enum logic {OPB_REG = 1'b0, OPB_IMM = 1'b1} opb_sel_e;
  typedef enum logic {SHAMT_FIELD = 1'b0, SHAMT_RS = 1'b1} shift_src_e;

  typedef struct packed {
    logic       writes;
    alu_op_e    op;
    shift_src_e sh;
    ext_mode_e  ext;
    opb_sel_e   opb;
    logic       dest_rd;
  } alu_ctl_t;

  typedef struct packed {
    logic jump;
    logic branch;
    logic load;
    logic store;
  } class_t;

  localparam alu_ctl_t CTL_NONE = '{writes: 1'b0, op: ALU_ADD, sh: SHAMT_FIELD,
                                     ext: EXT_SIGN, opb: OPB_REG, dest_rd: 1'b0};

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00, OPC_REGIMM = 6'h01,
    OPC_J = 6'h02, OPC_JAL = 6'h03, OPC_BEQ = 6'h04, OPC_BNE = 6'h05,
    OPC_BLEZ = 6'h06, OPC_BGTZ = 6'h07, OPC_ADDIU = 6'h09, OPC_SLTI = 6'h0A,
    OPC_SLTIU = 6'h0B, OPC_ANDI = 6'h0C, OPC_ORI = 6'h0D, OPC_XORI = 6'h0E,
    OPC_LUI = 6'h0F, OPC_LB = 6'h20, OPC_LW = 6'h23, OPC_LBU = 6'h24,
    OPC_SB = 6'h28, OPC_SW = 6'h2B;

  localparam logic [FN_W-1:0] FN_SLL = 6'h00, FN_SRL = 6'h02, FN_SRA = 6'h03,
    FN_SLLV = 6'h04, FN_SRLV = 6'h06, FN_SRAV = 6'h07, FN_JR = 6'h08,
    FN_JALR = 6'h09, FN_ADDU = 6'h21, FN_SUBU = 6'h23, FN_AND = 6'h24,
    FN_OR = 6'h25, FN_XOR = 6'h26, FN_NOR = 6'h27, FN_SLT = 6'h2A, FN_SLTU = 6'h2B;

  localparam logic [REG_W-1:0] RI_BLTZ = 5'd0, RI_BGEZ = 5'd1;
endpackage

// File: rtl/mdec_special.sv
module mdec_special
  import mdec_pkg::*;
(
  input  logic [FN_W-1:0] fn_i,
  output alu_ctl_t        ctl_o
);
  function automatic alu_ctl_t rform(input alu_op_e op, input shift_src_e sh);
    alu_ctl_t c;
    c         = CTL_NONE;
    c.writes  = 1'b1;
    c.op      = op;
    c.sh      = sh;
    c.opb     = OPB_REG;
    c.dest_rd = 1'b1;
    return c;
  endfunction

  always_comb begin
    unique case (fn_i)
      FN_ADDU: ctl_o = rform(ALU_ADD,  SHAMT_FIELD);
      FN_SUBU: ctl_o = rform(ALU_SUB,  SHAMT_FIELD);
      FN_AND:  ctl_o = rform(ALU_AND,  SHAMT_FIELD);
      FN_OR:   ctl_o = rform(ALU_OR,   SHAMT_FIELD);
      FN_XOR:  ctl_o = rform(ALU_XOR,  SHAMT_FIELD);
      FN_NOR:  ctl_o = rform(ALU_NOR,  SHAMT_FIELD);
      FN_SLT:  ctl_o = rform(ALU_SLT,  SHAMT_FIELD);
      FN_SLTU: ctl_o = rform(ALU_SLTU, SHAMT_FIELD);
      FN_SLL:  ctl_o = rform(ALU_SLL,  SHAMT_FIELD);
      FN_SRL:  ctl_o = rform(ALU_SRL,  SHAMT_FIELD);
      FN_SRA:  ctl_o = rform(ALU_SRA,  SHAMT_FIELD);
      FN_SLLV: ctl_o = rform(ALU_SLL,  SHAMT_RS);
      FN_SRLV: ctl_o = rform(ALU_SRL,  SHAMT_RS);
      FN_SRAV: ctl_o = rform(ALU_SRA,  SHAMT_RS);
      default: ctl_o = CTL_NONE;
    endcase
  end
endmodule

// File: rtl/mdec_immed.sv
module mdec_immed
  import mdec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output alu_ctl_t         ctl_o
);
  function automatic alu_ctl_t iform(input alu_op_e op, input ext_mode_e ext);
    alu_ctl_t c;
    c        = CTL_NONE;
    c.writes = 1'b1;
    c.op     = op;
    c.ext    = ext;
    c.opb    = OPB_IMM;
    return c;
  endfunction

  function automatic alu_ctl_t addr_form();
    alu_ctl_t c;
    c     = CTL_NONE;
    c.opb = OPB_IMM;
    return c;
  endfunction

  always_comb begin
    unique case (opc_i)
      OPC_ADDIU: ctl_o = iform(ALU_ADD,   EXT_SIGN);
      OPC_SLTI:  ctl_o = iform(ALU_SLT,   EXT_SIGN);
      OPC_SLTIU: ctl_o = iform(ALU_SLTU,  EXT_SIGN);
      OPC_ANDI:  ctl_o = iform(ALU_AND,   EXT_ZERO);
      OPC_ORI:   ctl_o = iform(ALU_OR,    EXT_ZERO);
      OPC_XORI:  ctl_o = iform(ALU_XOR,   EXT_ZERO);
      OPC_LUI:   ctl_o = iform(ALU_PASSB, EXT_UPPER);
      OPC_LB, OPC_LW, OPC_LBU, OPC_SB, OPC_SW: ctl_o = addr_form();
      default:   ctl_o = CTL_NONE;
    endcase
  end
endmodule

// File: rtl/mdec_class.sv
module mdec_class
  import mdec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [REG_W-1:0] rt_i,
  output class_t           cls_o
);
  logic special, regimm;

  always_comb begin
    special = (opc_i == OPC_SPECIAL);
    regimm  = (opc_i == OPC_REGIMM);
    cls_o.jump   = (opc_i == OPC_J) || (opc_i == OPC_JAL) ||
                   (special && ((fn_i == FN_JR) || (fn_i == FN_JALR)));
    cls_o.branch = (opc_i == OPC_BEQ) || (opc_i == OPC_BNE) ||
                   (opc_i == OPC_BLEZ) || (opc_i == OPC_BGTZ) ||
                   (regimm && ((rt_i == RI_BLTZ) || (rt_i == RI_BGEZ)));
    cls_o.load   = (opc_i == OPC_LB) || (opc_i == OPC_LW) || (opc_i == OPC_LBU);
    cls_o.store  = (opc_i == OPC_SB) || (opc_i == OPC_SW);
  end
endmodule

// File: rtl/mips_subset_decoder.sv
module mips_subset_decoder
  import mdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic [ALU_W-1:0]   alu_op_o,
  output logic               shift_src_o,
  output logic [1:0]         ext_mode_o,
  output logic               opb_sel_o,
  output logic [REG_W-1:0]   dest_idx_o,
  output logic               reg_we_o,
  output logic               is_jump_o,
  output logic               is_branch_o,
  output logic               is_load_o,
  output logic               is_store_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;

  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic [REG_W-1:0] rt, rd, dest;
  logic [9:0]       unused_bits;
  alu_ctl_t         sp_ctl, im_ctl, ctl;
  class_t           cls;

  assign opc         = instr_i[INSTR_W-1:OPC_LSB];
  assign fn          = instr_i[FN_W-1:0];
  assign rt          = instr_i[RT_LSB+REG_W-1:RT_LSB];
  assign rd          = instr_i[RD_LSB+REG_W-1:RD_LSB];
  assign unused_bits = {instr_i[25:21], instr_i[10:6]};

  mdec_special u_special (.fn_i(fn), .ctl_o(sp_ctl));
  mdec_immed   u_immed   (.opc_i(opc), .ctl_o(im_ctl));
  mdec_class   u_class   (.opc_i(opc), .fn_i(fn), .rt_i(rt), .cls_o(cls));

  always_comb begin
    ctl  = (opc == OPC_SPECIAL) ? sp_ctl : im_ctl;
    dest = '0;
    if (ctl.writes) dest = ctl.dest_rd ? rd : rt;
  end

  assign alu_op_o    = ctl.op;
  assign shift_src_o = ctl.sh;
  assign ext_mode_o  = ctl.ext;
  assign opb_sel_o   = ctl.opb;
  assign dest_idx_o  = dest;
  assign reg_we_o    = ctl.writes && (dest != '0);
  assign is_jump_o   = cls.jump;
  assign is_branch_o = cls.branch;
  assign is_load_o   = cls.load;
  assign is_store_o  = cls.store;
endmodule

// File: rtl/mips_subset_decoder_chk.sv
module mips_subset_decoder_chk (
  input logic [31:0] instr_i,
  input logic [3:0]  alu_op_o,
  input logic        shift_src_o,
  input logic [1:0]  ext_mode_o,
  input logic        opb_sel_o,
  input logic [4:0]  dest_idx_o,
  input logic        reg_we_o,
  input logic        is_jump_o,
  input logic        is_branch_o,
  input logic        is_load_o,
  input logic        is_store_o
);
  always_comb begin
    if (reg_we_o)
      assert_no_write_r0_R5: assert (dest_idx_o != 5'd0);
    assert_one_class_R9: assert ($onehot0({is_jump_o, is_branch_o, is_load_o, is_store_o}));
    if (is_jump_o || is_branch_o || is_load_o || is_store_o)
      assert_flagged_no_write_R6: assert (!reg_we_o);
    if (instr_i[31:26] == 6'h0F)
      assert_upper_imm_R3: assert (ext_mode_o == 2'd2 && opb_sel_o);
    if (opb_sel_o && reg_we_o)
      assert_imm_dest_rt_R2: assert (dest_idx_o == instr_i[20:16]);
    if (shift_src_o)
      assert_var_shift_op_R4: assert (alu_op_o inside {4'd8, 4'd9, 4'd10});
  end
endmodule

bind mips_subset_decoder mips_subset_decoder_chk u_chk (
  .instr_i(instr_i), .alu_op_o(alu_op_o), .shift_src_o(shift_src_o),
  .ext_mode_o(ext_mode_o), .opb_sel_o(opb_sel_o), .dest_idx_o(dest_idx_o),
  .reg_we_o(reg_we_o), .is_jump_o(is_jump_o), .is_branch_o(is_branch_o),
  .is_load_o(is_load_o), .is_store_o(is_store_o)
);

// File: tb/mips_subset_decoder_tb.sv
`timescale 1ns/1ps
module mips_subset_decoder_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [3:0]  alu_op;
  logic        shift_src, opb_sel, reg_we, is_j, is_b, is_l, is_s;
  logic [1:0]  ext_mode;
  logic [4:0]  dest;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  typedef struct {
    logic [31:0] ins;
    logic [17:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  mips_subset_decoder u_dut (
    .instr_i(instr), .alu_op_o(alu_op), .shift_src_o(shift_src),
    .ext_mode_o(ext_mode), .opb_sel_o(opb_sel), .dest_idx_o(dest),
    .reg_we_o(reg_we), .is_jump_o(is_j), .is_branch_o(is_b),
    .is_load_o(is_l), .is_store_o(is_s)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] rtype(input logic [4:0] rs, rt, rd, sa, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, sa, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  // exp = {op, shift_src, ext, opb, dest, we, jump, branch, load, store}
  function automatic logic [17:0] mk(input logic [3:0] op, input logic sh, input logic [1:0] ext,
                                     input logic opb, input logic [4:0] d, input logic we,
                                     input logic [3:0] cls);
    return {op, sh, ext, opb, d, we, cls};
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [17:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    instr  = ins;
    it.ins = ins; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      logic [17:0] act;
      it  = q.pop_front();
      act = {alu_op, shift_src, ext_mode, opb_sel, dest, reg_we, is_j, is_b, is_l, is_s};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s instr=%h actual=%h expected=%h", it.tag, it.ins, act, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R5: all-zero word is a no-op
    drive(32'd0, mk(4'd8, 0, 2'd0, 0, 5'd0, 0, 4'b0000), "R5 zero word");
    // R1 register arithmetic
    drive(rtype(5'd1, 5'd2, 5'd3,  5'd0, 6'h21), mk(4'd0, 0, 0, 0, 5'd3,  1, 4'b0), "R1 addu");
    drive(rtype(5'd4, 5'd5, 5'd31, 5'd0, 6'h23), mk(4'd1, 0, 0, 0, 5'd31, 1, 4'b0), "R1 subu");
    drive(rtype(5'd4, 5'd5, 5'd12, 5'd0, 6'h24), mk(4'd2, 0, 0, 0, 5'd12, 1, 4'b0), "R1 and");
    drive(rtype(5'd6, 5'd1, 5'd7,  5'd0, 6'h27), mk(4'd5, 0, 0, 0, 5'd7,  1, 4'b0), "R1 nor");
    drive(rtype(5'd6, 5'd1, 5'd9,  5'd0, 6'h2A), mk(4'd6, 0, 0, 0, 5'd9,  1, 4'b0), "R1 slt");
    drive(rtype(5'd6, 5'd1, 5'd9,  5'd0, 6'h2B), mk(4'd7, 0, 0, 0, 5'd9,  1, 4'b0), "R1 sltu");
    // R4 shifts
    drive(rtype(5'd0, 5'd2, 5'd4, 5'd5,  6'h00), mk(4'd8,  0, 0, 0, 5'd4, 1, 4'b0), "R4 sll");
    drive(rtype(5'd0, 5'd2, 5'd4, 5'd31, 6'h03), mk(4'd10, 0, 0, 0, 5'd4, 1, 4'b0), "R4 sra");
    drive(rtype(5'd3, 5'd2, 5'd6, 5'd0,  6'h06), mk(4'd9,  1, 0, 0, 5'd6, 1, 4'b0), "R4 srlv");
    drive(rtype(5'd3, 5'd2, 5'd6, 5'd0,  6'h07), mk(4'd10, 1, 0, 0, 5'd6, 1, 4'b0), "R4 srav");
    // R2 / R3 immediates
    drive(itype(6'h09, 5'd1, 5'd8,  16'hFFFF), mk(4'd0,  0, 2'd0, 1, 5'd8,  1, 4'b0), "R2 addiu");
    drive(itype(6'h0A, 5'd1, 5'd10, 16'h8000), mk(4'd6,  0, 2'd0, 1, 5'd10, 1, 4'b0), "R3 slti sign");
    drive(itype(6'h0B, 5'd1, 5'd11, 16'h0001), mk(4'd7,  0, 2'd0, 1, 5'd11, 1, 4'b0), "R2 sltiu");
    drive(itype(6'h0C, 5'd1, 5'd2,  16'h00FF), mk(4'd2,  0, 2'd1, 1, 5'd2,  1, 4'b0), "R3 andi zero");
    drive(itype(6'h0D, 5'd1, 5'd3,  16'h1234), mk(4'd3,  0, 2'd1, 1, 5'd3,  1, 4'b0), "R3 ori zero");
    drive(itype(6'h0E, 5'd1, 5'd5,  16'h8001), mk(4'd4,  0, 2'd1, 1, 5'd5,  1, 4'b0), "R3 xori zero");
    drive(itype(6'h0F, 5'd0, 5'd14, 16'h0123), mk(4'd11, 0, 2'd2, 1, 5'd14, 1, 4'b0), "R3 lui upper");
    // R5 writes to register 0 suppressed
    drive(rtype(5'd1, 5'd2, 5'd0, 5'd0, 6'h21), mk(4'd0, 0, 0, 0, 5'd0, 0, 4'b0), "R5 addu to r0");
    drive(itype(6'h0D, 5'd1, 5'd0, 16'hAAAA),   mk(4'd3, 0, 2'd1, 1, 5'd0, 0, 4'b0), "R5 ori to r0");
    // R6 jumps
    drive({6'h02, 26'h0000024},                   mk(0, 0, 0, 0, 0, 0, 4'b1000), "R6 j");
    drive({6'h03, 26'h3FFFFFF},                   mk(0, 0, 0, 0, 0, 0, 4'b1000), "R6 jal");
    drive(rtype(5'd31, 5'd0, 5'd0,  5'd0, 6'h08), mk(0, 0, 0, 0, 0, 0, 4'b1000), "R6 jr");
    drive(rtype(5'd5,  5'd0, 5'd31, 5'd0, 6'h09), mk(0, 0, 0, 0, 0, 0, 4'b1000), "R6 jalr");
    // R7 branches
    drive(itype(6'h04, 5'd5, 5'd6, 16'hFFF4), mk(0, 0, 0, 0, 0, 0, 4'b0100), "R7 beq");
    drive(itype(6'h05, 5'd5, 5'd6, 16'h0004), mk(0, 0, 0, 0, 0, 0, 4'b0100), "R7 bne");
    drive(itype(6'h06, 5'd9, 5'd0, 16'h0010), mk(0, 0, 0, 0, 0, 0, 4'b0100), "R7 blez");
    drive(itype(6'h07, 5'd9, 5'd0, 16'h0010), mk(0, 0, 0, 0, 0, 0, 4'b0100), "R7 bgtz");
    drive(itype(6'h01, 5'd9, 5'd0, 16'h0008), mk(0, 0, 0, 0, 0, 0, 4'b0100), "R7 bltz");
    drive(itype(6'h01, 5'd9, 5'd1, 16'h0008), mk(0, 0, 0, 0, 0, 0, 4'b0100), "R7 bgez");
    // R8 memory
    drive(itype(6'h23, 5'd30, 5'd12, 16'hFFFC), mk(0, 0, 0, 1, 0, 0, 4'b0010), "R8 lw");
    drive(itype(6'h20, 5'd30, 5'd12, 16'h0001), mk(0, 0, 0, 1, 0, 0, 4'b0010), "R8 lb");
    drive(itype(6'h24, 5'd30, 5'd12, 16'h0002), mk(0, 0, 0, 1, 0, 0, 4'b0010), "R8 lbu");
    drive(itype(6'h2B, 5'd30, 5'd12, 16'h0000), mk(0, 0, 0, 1, 0, 0, 4'b0001), "R8 sw");
    drive(itype(6'h28, 5'd30, 5'd12, 16'h0003), mk(0, 0, 0, 1, 0, 0, 4'b0001), "R8 sb");
    // R9 / R10 other encodings
    drive(itype(6'h01, 5'd9, 5'd2, 16'h0008),    mk(0, 0, 0, 0, 0, 0, 4'b0), "R10 regimm rt2");
    drive(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h01),  mk(0, 0, 0, 0, 0, 0, 4'b0), "R10 fn 0x01");
    drive(itype(6'h3F, 5'd1, 5'd7, 16'h1111),    mk(0, 0, 0, 0, 0, 0, 4'b0), "R9 opcode 0x3F");
    drive(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h25),  mk(4'd3, 0, 0, 0, 5'd3, 1, 4'b0), "R9 or no flag");
    drive(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h26),  mk(4'd4, 0, 0, 0, 5'd3, 1, 4'b0), "R1 xor");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule